// File: doc/BRIEF.md
# Migratory Coherence Cache-Side Engine

This block is the cache end of a migratory coherence scheme for one site. It keeps a small direct-mapped set of one-word lines. Each line carries a tag, a data word and one of four protocol states: invalid, waiting for a fill, clean or dirty. A processor load or store that hits finishes in the cycle it is presented. A miss asks the home for the line and holds the processor until the home's fill arrives and is installed. The access then completes as a hit.

The home talks to the engine through an inbound message queue that carries fills and recalls. The engine answers through a one-entry outbound slot that carries fetch requests, clean releases and dirty write-backs. Both edges use valid/ready handshakes.

A recall takes a line back. A clean line is released without data, and a dirty line is written back with its data. A recall that finds no valid copy is consumed silently, because the copy it aims at has already left on an earlier message. Only one miss may be outstanding at a time. Recalls keep being served while that miss waits.

Top module: `mig_cache_engine`

## Requirements
- R1: After reset every line is invalid, the outbound slot is empty and `cpu_done` is low. The first access to any address therefore misses.
- R2: A load or store that misses, with no valid conflicting line at its index, emits one fetch message (`out_kind` = 0) carrying the requested address. `cpu_done` stays low until the fill has been installed.
- R3: A fill (`in_kind` = 0) is accepted only while a miss waits. It installs the line clean with `in_data`. In the following cycle the held access completes: `cpu_done` is high and, for a load, `cpu_rdata` equals the filled word.
- R4: A store that hits completes at once and writes `cpu_wdata` into the line, which becomes dirty.
- R5: A recall (`in_kind` = 1) whose address matches a clean line emits a release (`out_kind` = 1) with that address and leaves the line invalid.
- R6: A recall whose address matches a dirty line emits a write-back (`out_kind` = 2) with that address and the line's data, and leaves the line invalid.
- R7: A recall whose line is invalid, waiting for a fill, or holds a different tag is consumed, emits nothing and leaves the line unchanged.
- R8: A miss whose index holds a valid line with another tag first emits that line's release or write-back, using the victim's own address. The fetch for the new address follows.
- R9: While a miss waits for its fill, recalls for other lines are still accepted and answered.
- R10: At most one fetch is outstanding. While a miss waits, no further fetch is issued.
- R11: While `out_valid` is high and `out_ready` is low, the outbound message and its fields hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access present; held until `cpu_done` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| in_valid | input | 1 | Inbound message present |
| in_ready | output | 1 | Inbound message consumed this cycle |
| in_kind | input | 1 | 0 = fill, 1 = recall |
| in_addr | input | ADDR_W | Address named by the inbound message |
| in_data | input | DATA_W | Fill data |
| out_valid | output | 1 | Outbound message present |
| out_ready | input | 1 | Outbound message taken this cycle |
| out_kind | output | 2 | 0 = fetch, 1 = release, 2 = write-back |
| out_addr | output | ADDR_W | Address named by the outbound message |
| out_data | output | DATA_W | Write-back data, zero otherwise |

## Verification
The assertions take for granted that the processor holds its access steady until `cpu_done`. They also assume the home sends a fill only after taking the fetch it answers, and keeps its messages in order. The directed tasks respect this: each access is held until it completes, and each fill is pushed only after the matching fetch has been checked and drained. Recalls for a waiting line, or for a line that is already gone, are sent only where the stated ordering makes them legitimate.

// File: rtl/mce_pkg.sv
package mce_pkg;

   typedef enum logic [1:0] {
      LN_INVALID = 2'd0,
      LN_PENDING = 2'd1,
      LN_CLEAN   = 2'd2,
      LN_DIRTY   = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      OUT_FETCH     = 2'd0,
      OUT_RELEASE   = 2'd1,
      OUT_WRITEBACK = 2'd2
   } out_kind_e;

   localparam logic IN_FILL   = 1'b0;
   localparam logic IN_RECALL = 1'b1;

   typedef enum logic {
      MD_RUN  = 1'b0,
      MD_WAIT = 1'b1
   } mode_e;

endpackage

// File: rtl/mce_line_array.sv
module mce_line_array
   import mce_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output line_st_e          rd_a_st,
   output logic [TAG_W-1:0]  rd_a_tag,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output line_st_e          rd_b_st,
   output logic [TAG_W-1:0]  rd_b_tag,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  line_st_e          wr_st,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);

   line_st_e          st_arr  [LINES];
   logic [TAG_W-1:0]  tag_arr [LINES];
   logic [DATA_W-1:0] dat_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e          st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] dat_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= LN_INVALID;
            tag_q <= '0;
            dat_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            st_q  <= wr_st;
            tag_q <= wr_tag;
            dat_q <= wr_data;
         end
      end

      assign st_arr[g]  = st_q;
      assign tag_arr[g] = tag_q;
      assign dat_arr[g] = dat_q;
   end

   assign rd_a_st   = st_arr[rd_a_idx];
   assign rd_a_tag  = tag_arr[rd_a_idx];
   assign rd_a_data = dat_arr[rd_a_idx];
   assign rd_b_st   = st_arr[rd_b_idx];
   assign rd_b_tag  = tag_arr[rd_b_idx];
   assign rd_b_data = dat_arr[rd_b_idx];

endmodule

// File: rtl/mce_out_slot.sv
module mce_out_slot #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 16,
   parameter bit BYPASS_DRAIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        ld_kind,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   output logic              slot_free,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);

   logic              v_q;
   logic [1:0]        k_q;
   logic [ADDR_W-1:0] a_q;
   logic [DATA_W-1:0] d_q;

   if (BYPASS_DRAIN) begin : g_bypass
      assign slot_free = !v_q || out_ready;
   end else begin : g_plain
      assign slot_free = !v_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         k_q <= '0;
         a_q <= '0;
         d_q <= '0;
      end else if (load) begin
         v_q <= 1'b1;
         k_q <= ld_kind;
         a_q <= ld_addr;
         d_q <= ld_data;
      end else if (out_ready) begin
         v_q <= 1'b0;
      end
   end

   assign out_valid = v_q;
   assign out_kind  = k_q;
   assign out_addr  = a_q;
   assign out_data  = d_q;

endmodule

// File: rtl/mig_cache_engine.sv
module mig_cache_engine
   import mce_pkg::*;
#(
   parameter int LINES        = 4,
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 16,
   parameter bit BYPASS_DRAIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_kind,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);

   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   // address split
   logic [IDX_W-1:0] cpu_idx, rc_idx;
   logic [TAG_W-1:0] cpu_tag, rc_tag;
   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign rc_idx  = in_addr[IDX_W-1:0];
   assign rc_tag  = in_addr[ADDR_W-1:IDX_W];

   // line array
   line_st_e          a_st, b_st, wr_st;
   logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
   logic [DATA_W-1:0] a_data, b_data, wr_data;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;

   mce_line_array #(
      .LINES (LINES),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
   ) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (cpu_idx),
      .rd_a_st  (a_st),
      .rd_a_tag (a_tag),
      .rd_a_data(a_data),
      .rd_b_idx (rc_idx),
      .rd_b_st  (b_st),
      .rd_b_tag (b_tag),
      .rd_b_data(b_data),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_st    (wr_st),
      .wr_tag   (wr_tag),
      .wr_data  (wr_data)
   );

   // outbound slot
   logic              ld, slot_free;
   out_kind_e         ld_kind;
   logic [ADDR_W-1:0] ld_addr;
   logic [DATA_W-1:0] ld_data;

   mce_out_slot #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .BYPASS_DRAIN(BYPASS_DRAIN)
   ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .ld_kind  (ld_kind),
      .ld_addr  (ld_addr),
      .ld_data  (ld_data),
      .slot_free(slot_free),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_kind (out_kind),
      .out_addr (out_addr),
      .out_data (out_data)
   );

   // control state
   mode_e            mode_q, mode_d;
   logic [IDX_W-1:0] pend_idx_q;
   logic [TAG_W-1:0] pend_tag_q;
   logic             pend_cap;

   logic a_valid, a_hit, a_victim, b_hit;
   assign a_valid  = (a_st == LN_CLEAN) || (a_st == LN_DIRTY);
   assign a_hit    = a_valid && (a_tag == cpu_tag);
   assign a_victim = a_valid && (a_tag != cpu_tag);
   assign b_hit    = ((b_st == LN_CLEAN) || (b_st == LN_DIRTY)) && (b_tag == rc_tag);

   logic recall_in, fill_in;
   assign recall_in = in_valid && (in_kind == IN_RECALL);
   assign fill_in   = in_valid && (in_kind == IN_FILL);

   always_comb begin
      in_ready = 1'b0;
      cpu_done = 1'b0;
      wr_en    = 1'b0;
      wr_idx   = cpu_idx;
      wr_st    = a_st;
      wr_tag   = a_tag;
      wr_data  = a_data;
      ld       = 1'b0;
      ld_kind  = OUT_FETCH;
      ld_addr  = cpu_addr;
      ld_data  = '0;
      mode_d   = mode_q;
      pend_cap = 1'b0;

      if (recall_in) begin
         // recalls take precedence over everything else
         if (slot_free) begin
            in_ready = 1'b1;
            if (b_hit) begin
               ld      = 1'b1;
               ld_kind = (b_st == LN_DIRTY) ? OUT_WRITEBACK : OUT_RELEASE;
               ld_addr = in_addr;
               ld_data = (b_st == LN_DIRTY) ? b_data : '0;
               wr_en   = 1'b1;
               wr_idx  = rc_idx;
               wr_st   = LN_INVALID;
               wr_tag  = b_tag;
               wr_data = b_data;
            end
         end
      end else if (mode_q == MD_WAIT) begin
         if (fill_in) begin
            in_ready = 1'b1;
            wr_en    = 1'b1;
            wr_idx   = pend_idx_q;
            wr_st    = LN_CLEAN;
            wr_tag   = pend_tag_q;
            wr_data  = in_data;
            mode_d   = MD_RUN;
         end
      end else if (cpu_valid) begin
         if (a_hit) begin
            cpu_done = 1'b1;
            if (cpu_write) begin
               wr_en   = 1'b1;
               wr_st   = LN_DIRTY;
               wr_data = cpu_wdata;
            end
         end else if (slot_free) begin
            ld = 1'b1;
            if (a_victim) begin
               ld_kind = (a_st == LN_DIRTY) ? OUT_WRITEBACK : OUT_RELEASE;
               ld_addr = {a_tag, cpu_idx};
               ld_data = (a_st == LN_DIRTY) ? a_data : '0;
               wr_en   = 1'b1;
               wr_st   = LN_INVALID;
            end else begin
               ld_kind  = OUT_FETCH;
               ld_addr  = cpu_addr;
               wr_en    = 1'b1;
               wr_st    = LN_PENDING;
               wr_tag   = cpu_tag;
               mode_d   = MD_WAIT;
               pend_cap = 1'b1;
            end
         end
      end
   end

   assign cpu_rdata = a_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MD_RUN;
         pend_idx_q <= '0;
         pend_tag_q <= '0;
      end else begin
         mode_q <= mode_d;
         if (pend_cap) begin
            pend_idx_q <= cpu_idx;
            pend_tag_q <= cpu_tag;
         end
      end
   end

endmodule

// File: rtl/mce_checker.sv
module mce_checker
   import mce_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_valid,
   input logic              cpu_done,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_kind,
   input logic              out_valid,
   input logic              out_ready,
   input logic [1:0]        out_kind,
   input logic [ADDR_W-1:0] out_addr,
   input logic [DATA_W-1:0] out_data
);

   logic fetch_fire, fill_fire, outstanding_q;
   assign fetch_fire = out_valid && out_ready && (out_kind == OUT_FETCH);
   assign fill_fire  = in_valid && in_ready && (in_kind == IN_FILL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          outstanding_q <= 1'b0;
      else if (fetch_fire) outstanding_q <= 1'b1;
      else if (fill_fire)  outstanding_q <= 1'b0;
   end

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_addr) && $stable(out_data))
      else $error("outbound message changed under back-pressure");

   p_one_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_fire |-> !outstanding_q)
      else $error("second fetch while one outstanding");

   p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding_q |-> !cpu_done)
      else $error("access completed while miss outstanding");

   p_done_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> cpu_valid)
      else $error("completion without a request");

   p_fill_expected_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_fire |-> outstanding_q)
      else $error("fill taken with no miss outstanding");

   p_kind_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_kind != 2'd3))
      else $error("illegal outbound kind");

endmodule

bind mig_cache_engine mce_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_mce_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_valid(cpu_valid),
   .cpu_done (cpu_done),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_kind  (in_kind),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_kind (out_kind),
   .out_addr (out_addr),
   .out_data (out_data)
);

// File: tb/mig_cache_engine_bench.sv
module mig_cache_engine_bench;

   localparam int LINES  = 4;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;

   localparam logic [ADDR_W-1:0] A_ADDR = 8'h11;  // index 1
   localparam logic [ADDR_W-1:0] B_ADDR = 8'h21;  // index 1, other tag
   localparam logic [ADDR_W-1:0] C_ADDR = 8'h32;  // index 2
   localparam logic [ADDR_W-1:0] C_ALIAS = 8'h72; // index 2, other tag

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_valid = 1'b0, cpu_write = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic              cpu_done;
   logic [DATA_W-1:0] cpu_rdata;
   logic              in_valid = 1'b0, in_kind = 1'b0;
   logic              in_ready;
   logic [ADDR_W-1:0] in_addr = '0;
   logic [DATA_W-1:0] in_data = '0;
   logic              out_valid, out_ready = 1'b1;
   logic [1:0]        out_kind;
   logic [ADDR_W-1:0] out_addr;
   logic [DATA_W-1:0] out_data;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   mig_cache_engine #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mig_cache_engine (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_addr(in_addr), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_addr(out_addr),
      .out_data(out_data)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic push_in(logic kind, logic [ADDR_W-1:0] addr, logic [DATA_W-1:0] data, string req);
      int n = 0;
      in_valid = 1'b1; in_kind = kind; in_addr = addr; in_data = data;
      #1;
      while (!in_ready && n < 50) begin @(negedge clk); #1; n++; end
      chk(req, "inbound accepted", 32'(in_ready), 32'd1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_out(logic [1:0] kind, logic [ADDR_W-1:0] addr, logic [DATA_W-1:0] data, string req);
      int n = 0;
      #1;
      while (!out_valid && n < 50) begin @(negedge clk); #1; n++; end
      chk(req, "out_valid", 32'(out_valid), 32'd1);
      chk(req, "out_kind", 32'(out_kind), 32'(kind));
      chk(req, "out_addr", 32'(out_addr), 32'(addr));
      chk(req, "out_data", 32'(out_data), 32'(data));
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_quiet(int cycles, string req);
      for (int i = 0; i < cycles; i++) begin
         #1;
         chk(req, "no outbound message", 32'(out_valid), 32'd0);
         @(negedge clk);
      end
   endtask

   task automatic start_cpu(logic wr, logic [ADDR_W-1:0] addr, logic [DATA_W-1:0] wd);
      cpu_valid = 1'b1; cpu_write = wr; cpu_addr = addr; cpu_wdata = wd;
   endtask

   task automatic hit(logic wr, logic [ADDR_W-1:0] addr, logic [DATA_W-1:0] wd,
                      logic [DATA_W-1:0] exp_rd, string req);
      start_cpu(wr, addr, wd);
      #1;
      chk(req, "hit completes at once", 32'(cpu_done), 32'd1);
      if (!wr) chk(req, "hit read data", 32'(cpu_rdata), 32'(exp_rd));
      @(posedge clk);
      @(negedge clk);
      cpu_valid = 1'b0;
   endtask

   // after the fetch has been seen: deliver fill and complete
   task automatic finish_miss(logic [DATA_W-1:0] fill, string req);
      #1;
      chk(req, "held before fill", 32'(cpu_done), 32'd0);
      push_in(1'b0, cpu_addr, fill, req);
      #1;
      chk(req, "completes after fill", 32'(cpu_done), 32'd1);
      if (!cpu_write) chk(req, "filled read data", 32'(cpu_rdata), 32'(fill));
      @(posedge clk);
      @(negedge clk);
      cpu_valid = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
      chk("R1", "cpu_done after reset", 32'(cpu_done), 32'd0);
   endtask

   task automatic t_load_miss;
      start_cpu(1'b0, A_ADDR, '0);
      expect_out(2'd0, A_ADDR, '0, "R1 R2 fetch on cold miss");
      expect_quiet(3, "R10 no second fetch");
      finish_miss(16'hA5A5, "R3");
   endtask

   task automatic t_store_and_writeback;
      hit(1'b1, A_ADDR, 16'h1234, '0, "R4 store hit");
      push_in(1'b1, A_ADDR, '0, "R6");
      expect_out(2'd2, A_ADDR, 16'h1234, "R6 dirty write-back");
      start_cpu(1'b0, A_ADDR, '0);
      expect_out(2'd0, A_ADDR, '0, "R6 line left invalid");
      finish_miss(16'h0F0F, "R3");
   endtask

   task automatic t_recall_clean;
      push_in(1'b1, A_ADDR, '0, "R5");
      expect_out(2'd1, A_ADDR, '0, "R5 clean release");
      push_in(1'b1, A_ADDR, '0, "R7");
      expect_quiet(4, "R7 recall on invalid line");
      start_cpu(1'b0, A_ADDR, '0);
      expect_out(2'd0, A_ADDR, '0, "R5 line left invalid");
      finish_miss(16'h3C3C, "R3");
   endtask

   task automatic t_recall_mismatch;
      start_cpu(1'b0, C_ADDR, '0);
      expect_out(2'd0, C_ADDR, '0, "R2 fetch C");
      finish_miss(16'h4242, "R3");
      push_in(1'b1, C_ALIAS, '0, "R7");
      expect_quiet(4, "R7 recall with other tag");
      hit(1'b0, C_ADDR, '0, 16'h4242, "R7 line unchanged");
   endtask

   task automatic t_evict;
      hit(1'b1, A_ADDR, 16'h5555, '0, "R4 store hit");
      start_cpu(1'b0, B_ADDR, '0);
      expect_out(2'd2, A_ADDR, 16'h5555, "R8 victim write-back first");
      expect_out(2'd0, B_ADDR, '0, "R8 fetch after victim");
      finish_miss(16'h7777, "R3");
   endtask

   task automatic t_recall_while_pending;
      start_cpu(1'b0, A_ADDR, '0);
      expect_out(2'd1, B_ADDR, '0, "R8 clean victim release");
      expect_out(2'd0, A_ADDR, '0, "R8 fetch A");
      push_in(1'b1, C_ADDR, '0, "R9");
      expect_out(2'd1, C_ADDR, '0, "R9 recall served during miss");
      push_in(1'b1, A_ADDR, '0, "R7");
      expect_quiet(3, "R7 recall on waiting line");
      finish_miss(16'h9999, "R3");
   endtask

   task automatic t_backpressure;
      out_ready = 1'b0;
      push_in(1'b1, A_ADDR, '0, "R11");
      #1;
      chk("R11", "out_valid under stall", 32'(out_valid), 32'd1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); #1;
         chk("R11", "held valid", 32'(out_valid), 32'd1);
         chk("R11", "held kind", 32'(out_kind), 32'd1);
         chk("R11", "held addr", 32'(out_addr), 32'(A_ADDR));
      end
      @(negedge clk);
      out_ready = 1'b1;
      expect_out(2'd1, A_ADDR, '0, "R11 drained after stall");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      @(negedge clk);
      t_load_miss();
      t_store_and_writeback();
      t_recall_clean();
      t_recall_mismatch();
      t_evict();
      t_recall_while_pending();
      t_backpressure();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule